// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block owns eight general-purpose pins and presents them to software through a small memory-mapped window. A direction register decides, pin by pin, whether the pin is driven by the chip or sampled from outside. A single data register holds both the values being driven on output pins and the values captured from input pins.

Data accesses are unusual in one way: the word offset of the access carries a per-pin mask. A read returns only the pins selected by that mask. A write changes only pins that are selected by the mask and are also configured as outputs. Software can therefore set or clear any subset of output pins in one store without a read-modify-write sequence, and two agents that own different pins never disturb each other. Input levels pass through a two-flop synchroniser before they reach the data register. The pin outputs are registered.

The register window is reached through a request channel and a response channel, each with valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every request that is taken returns exactly one response. Only one response can be outstanding, so `req_ready` is low while a response waits. The response stays valid, with its data held, until a clock edge where `rsp_ready` is high. This is how the consumer applies back-pressure.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction and data registers are zero, every `pin_out` line is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write to byte offset 0x400 stores the low 8 bits of `req_wdata` as the direction register, with 1 meaning output and 0 meaning input. The upper bits are dropped. A read of offset 0x400 returns the stored value, zero-extended.
- R3: A read at any offset below 0x400 returns the data register ANDed with the mask taken from offset bits [9:2]. Unmasked pins and `rsp_rdata` bits [31:8] read as 0.
- R4: A write at any offset below 0x400 changes only the data bits that are set both in the offset mask (bits [9:2]) and in the direction register. Every other output bit keeps its value.
- R5: For each input pin (direction bit 0), the data bit follows `pin_in` through a two-flop synchroniser. For output pins, `pin_in` is ignored.
- R6: Each `pin_out` bit equals its data bit when the pin is an output and is 1 when the pin is an input. It is updated one clock after the data or direction register changes.
- R7: Reads of any other offset return 0, including offset 0x404, offsets above 0x400 and offsets that are not word-aligned such as 0x401. Writes to these offsets change no state.
- R8: Each accepted request produces exactly one response, and a write's response carries zero data. `req_ready` is low while a response is pending. A pending response keeps `rsp_valid` high and `rsp_rdata` stable until it is consumed with `rsp_ready`.
- R9: When a pin turns from input to output, it drives the last value captured into its data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| pin_in | input | 8 | Asynchronous external pin levels |
| pin_out | output | 8 | Registered pin drive values |

## Verification
The bench targets the masked-write boundary with stores whose mask overlaps only input pins, and with stores whose mask is empty. A design that ignored the direction term would corrupt captured inputs, and one that ignored the mask would clobber pins that software did not select. It switches pins between input and output while external levels differ from the held data. This exposes a design that loses the captured value on the switch or lets outside levels leak onto output pins. Misaligned offsets and offsets just above the direction register are probed so that loose decoding would show up as a stray read or write. A response is then held under back-pressure to catch a design that drops it or accepts a second request while one is pending.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Decoded target of a register-window access
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } gpio_sel_e;
endpackage

// File: rtl/gpio_bus_port.sv
// Request/response handshake and address decode for the register window.
module gpio_bus_port
  import gpio_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int DIR_OFF = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  // towards the register file
  output logic              acc_wr,
  output gpio_sel_e         acc_sel,
  output logic [PINS-1:0]   acc_mask,
  output logic [PINS-1:0]   acc_wbits,
  input  logic [PINS-1:0]   rd_bits
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + PINS - 1;
  localparam int PAD_W   = DATA_W - PINS;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFF);

  logic              take;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              unused_wdata_hi;

  assign req_ready = ~rsp_valid_q;
  assign take      = req_valid & req_ready;

  always_comb begin
    if (req_addr < DIR_ADDR)       acc_sel = SEL_DATA;
    else if (req_addr == DIR_ADDR) acc_sel = SEL_DIR;
    else                           acc_sel = SEL_NONE;
  end

  assign acc_wr          = take & req_write;
  assign acc_mask        = req_addr[MASK_HI:MASK_LO];
  assign acc_wbits       = req_wdata[PINS-1:0];
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (take) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= req_write ? '0 : {{PAD_W{1'b0}}, rd_bits};
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/gpio_in_sync.sv
// Per-pin multi-flop synchroniser for asynchronous pin levels.
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_async,
  output logic [PINS-1:0] pin_sync
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_async[p]};
    end
    assign pin_sync[p] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_pin_regs.sv
// Direction and data registers plus registered pin drive.
module gpio_pin_regs
  import gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_wr,
  input  gpio_sel_e       acc_sel,
  input  logic [PINS-1:0] acc_mask,
  input  logic [PINS-1:0] acc_wbits,
  input  logic [PINS-1:0] pin_sync,
  output logic [PINS-1:0] rd_bits,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] data_q,
  output logic [PINS-1:0] pin_out
);
  logic wr_data_en;
  logic wr_dir_en;

  assign wr_data_en = acc_wr && (acc_sel == SEL_DATA);
  assign wr_dir_en  = acc_wr && (acc_sel == SEL_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= '0;
    else if (wr_dir_en) dir_q <= acc_wbits;
  end

  // Each data bit is either an output latch or an input capture.
  for (genvar p = 0; p < PINS; p++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[p] <= 1'b0;
      end else if (!dir_q[p]) begin
        data_q[p] <= pin_sync[p];
      end else if (wr_data_en && acc_mask[p]) begin
        data_q[p] <= acc_wbits[p];
      end
    end
  end

  // Input pins float high on the drive side.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= '1;
    else        pin_out <= data_q | ~dir_q;
  end

  always_comb begin
    unique case (acc_sel)
      SEL_DATA: rd_bits = data_q & acc_mask;
      SEL_DIR:  rd_bits = dir_q;
      default:  rd_bits = '0;
    endcase
  end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int DIR_OFF = 'h400,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out
);
  logic            acc_wr;
  gpio_sel_e       acc_sel;
  logic [PINS-1:0] acc_mask;
  logic [PINS-1:0] acc_wbits;
  logic [PINS-1:0] rd_bits;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] data_q;

  gpio_bus_port #(
    .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_OFF(DIR_OFF)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_mask(acc_mask),
    .acc_wbits(acc_wbits), .rd_bits(rd_bits)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync)
  );

  gpio_pin_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_mask(acc_mask),
    .acc_wbits(acc_wbits), .pin_sync(pin_sync),
    .rd_bits(rd_bits), .dir_q(dir_q), .data_q(data_q), .pin_out(pin_out)
  );
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int PINS    = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int DIR_OFF = 'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_sync,
  input logic [PINS-1:0]   dir_q,
  input logic [PINS-1:0]   data_q
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFF);

  logic data_wr;
  assign data_wr = req_valid && req_ready && req_write && (req_addr < DIR_ADDR);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rdata_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:PINS] == '0));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

  p_in_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((data_q ^ $past(pin_sync)) & ~$past(dir_q)) == '0));

  p_in_pins_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&(pin_out | $past(dir_q))));

  p_out_pins_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_out ^ $past(data_q)) & $past(dir_q)) == '0));
endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_OFF(DIR_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pin_out(pin_out),
  .pin_sync(pin_sync), .dir_q(dir_q), .data_q(data_q)
);

// File: tb/test_gpio_masked_port.sv
module test_gpio_masked_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_masked_port i_gpio_masked_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out)
  );

  // {write, offset, wdata, pin_in, expected rdata, expected pin_out}
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h400, 8'h00, 8'h00, 8'h00, 8'hFF}, // R2 dir reads 0
    {1'b1, 12'h400, 8'h0F, 8'hA5, 8'h00, 8'hF5}, // R9 low pins keep captured 5
    {1'b0, 12'h3FC, 8'h00, 8'h3C, 8'h35, 8'hF5}, // R3 R5
    {1'b1, 12'h00C, 8'hFF, 8'h3C, 8'h00, 8'hF7}, // R4 mask 03
    {1'b1, 12'h3C0, 8'h00, 8'h3C, 8'h00, 8'hF7}, // R4 mask hits inputs only
    {1'b0, 12'h030, 8'h00, 8'h3C, 8'h04, 8'hF7}, // R3 mask 0C
    {1'b1, 12'h3FC, 8'h08, 8'hC0, 8'h00, 8'hF8}, // R4 full mask
    {1'b0, 12'h3FC, 8'h00, 8'hC0, 8'hC8, 8'hF8}, // R5
    {1'b1, 12'h400, 8'hF0, 8'h5A, 8'h00, 8'h5F}, // R9 R6
    {1'b0, 12'h3FC, 8'h00, 8'h00, 8'h50, 8'h5F}, // R5 outputs ignore pins
    {1'b1, 12'h404, 8'hFF, 8'h00, 8'h00, 8'h5F}, // R7 write ignored
    {1'b0, 12'h404, 8'h00, 8'h00, 8'h00, 8'h5F}, // R7
    {1'b0, 12'h400, 8'h00, 8'h00, 8'hF0, 8'h5F}, // R2
    {1'b0, 12'h7FC, 8'h00, 8'h00, 8'h00, 8'h5F}, // R7
    {1'b0, 12'h401, 8'h00, 8'h00, 8'h00, 8'h5F}, // R7 misaligned
    {1'b1, 12'h000, 8'hFF, 8'h00, 8'h00, 8'h5F}, // R4 empty mask
    {1'b0, 12'h3FC, 8'h00, 8'h00, 8'h50, 8'h5F}, // R4 unchanged
    {1'b1, 12'h400, 8'h00, 8'h00, 8'h00, 8'hFF}  // R6 all inputs high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives at a negedge; returns at the negedge after the accepting edge.
  task automatic issue(input logic wr, input logic [11:0] addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", {24'h0, pin_out}, 32'hFF);
    check("R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 req_ready", {31'h0, req_ready}, 32'h1);
    check("R1 pin_out after reset", {24'h0, pin_out}, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      pin_in = VEC[i][23:16];
      repeat (4) @(posedge clk);
      issue(VEC[i][44], VEC[i][43:32], {24'h0, VEC[i][31:24]});
      check("R8 response present", {31'h0, rsp_valid}, 32'h1);
      check($sformatf("R3 R7 R8 vector %0d rdata", i), rsp_rdata, {24'h0, VEC[i][15:8]});
      @(negedge clk);
      check($sformatf("R6 vector %0d pin_out", i), {24'h0, pin_out}, {24'h0, VEC[i][7:0]});
      check("R8 response consumed", {31'h0, rsp_valid}, 32'h0);
    end

    // R2: upper write bits dropped
    issue(1'b1, 12'h400, 32'hABCD_1203);
    @(negedge clk);
    issue(1'b0, 12'h400, 32'h0);
    check("R2 dir upper bits dropped", rsp_rdata, 32'h03);
    @(negedge clk);
    check("R6 pins before write", {24'h0, pin_out}, 32'hFC);

    // R6: output changes one clock after the data write
    issue(1'b1, 12'h00C, 32'h3);
    check("R6 pin_out not yet changed", {24'h0, pin_out}, 32'hFC);
    @(negedge clk);
    check("R6 pin_out after one clock", {24'h0, pin_out}, 32'hFF);

    // R8: back-pressure holds the response
    rsp_ready = 1'b0;
    issue(1'b0, 12'h400, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 held valid", {31'h0, rsp_valid}, 32'h1);
      check("R8 held rdata", rsp_rdata, 32'h03);
      check("R8 ready low while pending", {31'h0, req_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 released", {31'h0, rsp_valid}, 32'h0);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pin_out on reset", {24'h0, pin_out}, 32'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b0, 12'h400, 32'h0);
    check("R1 dir cleared", rsp_rdata, 32'h0);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule